// File: doc/BRIEF.md
# Burst column address sequencer

This block produces the column addresses of one DRAM-style read or write burst, one address per clock. A start pulse carries the first column, a length select (four or eight beats) and an ordering select (wrapping or interleaved). Starting on the next clock, the block issues the whole burst with a valid flag, and it raises a last flag on the final beat.

Only the low offset bits inside the burst boundary change from beat to beat. These are two bits for length four and three bits for length eight. Every column bit above the boundary is copied from the starting column. Length and ordering are captured with the start pulse, so later changes on those inputs cannot affect a burst that is already running. A new burst is taken only when the previous one has issued its last beat. A start on the last beat runs back to back with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` and `last_o` are 0 and `ready_o` is 1 until a start is accepted.
- R2: A start is accepted when `start_i` and `ready_o` are both 1 at a clock edge. The first beat appears on the next edge. The following beats come on consecutive edges with `valid_o` at 1, for 4 beats when `bl8_i`=0 and 8 beats when `bl8_i`=1.
- R3: Length four, wrapping (`bl8_i`=0, `ilv_i`=0): the offset in bits [1:0] of beat i is (start[1:0] + i) mod 4. For example, start 1 gives 1,2,3,0.
- R4: Length four, interleaved (`bl8_i`=0, `ilv_i`=1): the offset in bits [1:0] of beat i is start[1:0] XOR i. For example, start 3 gives 3,2,1,0.
- R5: Length eight, wrapping (`bl8_i`=1, `ilv_i`=0): bits [1:0] of beat i are (start[1:0] + i) mod 4. Bit 2 equals start[2] on beats 0–3 and is inverted on beats 4–7. For example, start 1 gives 1,2,3,0,5,6,7,4.
- R6: Length eight, interleaved (`bl8_i`=1, `ilv_i`=1): bits [2:0] of beat i are start[2:0] XOR i. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R7: On every beat, the column bits above the burst boundary (bits [COL_W-1:2] for length four, bits [COL_W-1:3] for length eight) equal those of the starting column.
- R8: `last_o` is 1 exactly on beat BL-1 of each burst and is never 1 without `valid_o`.
- R9: A start pulse while `ready_o` is 0 is ignored. The running burst continues unchanged, and no extra burst follows it.
- R10: Changes on `bl8_i`, `ilv_i` and `col_i` during a burst do not affect the addresses of that burst.
- R11: `ready_o` is 1 during the last beat. A start accepted on that beat makes its first beat appear on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a burst |
| col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | 1 selects eight beats, 0 selects four |
| ilv_i | input | 1 | 1 selects interleaved order, 0 selects wrapping order |
| ready_o | output | 1 | A start is accepted in this cycle |
| valid_o | output | 1 | `col_o` carries a beat of the burst |
| last_o | output | 1 | Current beat is the final one |
| col_o | output | COL_W | Column address of the current beat |

## Verification
The bench builds the block with the default ten-bit column. This leaves seven bits above the eight-beat boundary, and the bench fills them with random values, so any leak of the offset logic into the upper bits shows up. With that width, every one of the eight starting offsets can be swept under all four length and order combinations. Extra cases cover starts that arrive during a burst, selects that change mid-burst, and a start held high continuously so that bursts run back to back.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int OFS_W  = 3;
    localparam int BEAT_W = 3;

    typedef enum logic {
        ORDER_WRAP = 1'b0,
        ORDER_XOR  = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bcs_wrap_offset.sv
module bcs_wrap_offset
    import bcs_pkg::*;
(
    input  logic [OFS_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              eight_i,
    output logic [OFS_W-1:0]  ofs_o
);
    logic [1:0] low;

    always_comb begin
        low   = base_i[1:0] + beat_i[1:0];
        // bit 2 flips for the second half only in eight-beat bursts
        ofs_o = {base_i[2] ^ (eight_i & beat_i[2]), low};
    end
endmodule

// File: rtl/bcs_xor_offset.sv
module bcs_xor_offset
    import bcs_pkg::*;
(
    input  logic [OFS_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              eight_i,
    output logic [OFS_W-1:0]  ofs_o
);
    logic [BEAT_W-1:0] mask;

    always_comb begin
        mask  = {beat_i[2] & eight_i, beat_i[1:0]};
        ofs_o = base_i ^ mask;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             bl8_i,
    input  logic             ilv_i,
    output logic             ready_o,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] col_o
);
    localparam int HI_W = COL_W - OFS_W;
    localparam logic [BEAT_W-1:0] END4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] END8 = BEAT_W'(7);

    typedef struct packed {
        logic              active;
        logic              last;
        logic [BEAT_W-1:0] beat;
        logic              eight;
        burst_order_e      order;
        logic [HI_W-1:0]   hi;
        logic [OFS_W-1:0]  base;
        logic [COL_W-1:0]  col;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic              take;
    logic              run_on;
    logic [BEAT_W-1:0] beat_nx;
    logic [OFS_W-1:0]  base_sel;
    logic              eight_sel;
    burst_order_e      order_sel;
    logic [HI_W-1:0]   hi_sel;
    logic [OFS_W-1:0]  wrap_ofs;
    logic [OFS_W-1:0]  xor_ofs;
    logic [OFS_W-1:0]  ofs_sel;

    assign ready_o = !st_q.active || st_q.last;
    assign take    = start_i && ready_o;
    assign run_on  = st_q.active && !st_q.last;

    // operand select: fresh inputs on a start, captured values otherwise
    always_comb begin
        if (take) begin
            beat_nx   = '0;
            base_sel  = col_i[OFS_W-1:0];
            eight_sel = bl8_i;
            order_sel = burst_order_e'(ilv_i);
            hi_sel    = col_i[COL_W-1:OFS_W];
        end else begin
            beat_nx   = st_q.beat + 1'b1;
            base_sel  = st_q.base;
            eight_sel = st_q.eight;
            order_sel = st_q.order;
            hi_sel    = st_q.hi;
        end
    end

    bcs_wrap_offset u_wrap (
        .base_i  (base_sel),
        .beat_i  (beat_nx),
        .eight_i (eight_sel),
        .ofs_o   (wrap_ofs)
    );

    bcs_xor_offset u_xor (
        .base_i  (base_sel),
        .beat_i  (beat_nx),
        .eight_i (eight_sel),
        .ofs_o   (xor_ofs)
    );

    assign ofs_sel = (order_sel == ORDER_XOR) ? xor_ofs : wrap_ofs;

    always_comb begin
        st_d = st_q;
        if (take || run_on) begin
            st_d.active = 1'b1;
            st_d.beat   = beat_nx;
            st_d.eight  = eight_sel;
            st_d.order  = order_sel;
            st_d.hi     = hi_sel;
            st_d.base   = base_sel;
            st_d.col    = {hi_sel, ofs_sel};
            st_d.last   = (beat_nx == (eight_sel ? END8 : END4));
        end else begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.active;
    assign last_o  = st_q.last;
    assign col_o   = st_q.col;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready_o,
    input logic             valid_o,
    input logic             last_o,
    input logic [COL_W-1:0] col_o
);
    logic [3:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (valid_o && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ready_o);

    assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_last_on_final_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (cnt_q == 4'd3 || cnt_q == 4'd7));

    assert_beat_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cnt_q <= 4'd7);

    assert_burst_runs_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .col_o   (col_o)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic             bl8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic             ready_o, valid_o, last_o;
    logic [COL_W-1:0] col_o;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R3";

    typedef struct {
        int    col;
        bit    last;
        bit    eight;
        string tag;
    } beat_t;

    beat_t q[$];
    bit    e_valid = 0;
    bit    e_last  = 0;
    int    e_col   = 0;
    bit    e_eight = 0;
    string e_tag   = "R2";

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .bl8_i(bl8_i), .ilv_i(ilv_i), .ready_o(ready_o), .valid_o(valid_o),
        .last_o(last_o), .col_o(col_o)
    );

    // offset of beat i from the requirement formulas R3..R6
    function automatic int beat_ofs(int s, int i, bit eight, bit ilv);
        int lo;
        int b2;
        if (ilv) lo = (s ^ i) & 3;
        else     lo = (s + i) % 4;
        b2 = s & 4;
        if (eight && i >= 4) b2 = b2 ^ 4;
        return b2 | lo;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            e_valid <= 0;
            e_last  <= 0;
        end else begin
            bit rdy;
            rdy = !e_valid || e_last;
            if (start_i && rdy) begin
                int n;
                n = bl8_i ? 8 : 4;
                for (int i = 0; i < n; i++) begin
                    beat_t b;
                    b.col   = (int'(col_i) & ~7) | beat_ofs(int'(col_i) & 7, i, bl8_i, ilv_i);
                    b.last  = (i == n - 1);
                    b.eight = bl8_i;
                    b.tag   = cur_tag;
                    q.push_back(b);
                end
            end
            if (q.size() > 0) begin
                beat_t b;
                b = q.pop_front();
                e_valid <= 1;
                e_col   <= b.col;
                e_last  <= b.last;
                e_eight <= b.eight;
                e_tag   <= b.tag;
            end else begin
                e_valid <= 0;
                e_last  <= 0;
            end
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check("R2 valid", int'(valid_o), int'(e_valid));
            check("R8 last", int'(last_o), int'(e_last));
            check("R11 ready", int'(ready_o), int'(!e_valid || e_last));
            if (e_valid) begin
                check(e_tag, int'(col_o), e_col);
                if (e_eight) check("R7 upper", int'(col_o) >> 3, e_col >> 3);
                else         check("R7 upper", int'(col_o) >> 2, e_col >> 2);
            end
        end
    end

    task automatic run_burst(int col, bit eight, bit ilv, string tag);
        @(negedge clk);
        cur_tag = tag;
        col_i   = COL_W'(col);
        bl8_i   = eight;
        ilv_i   = ilv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!(valid_o && last_o)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        check("R1 reset valid", int'(valid_o), 0);
        check("R1 reset last", int'(last_o), 0);
        check("R1 reset ready", int'(ready_o), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", int'(valid_o), 0);
        check("R1 idle ready", int'(ready_o), 1);

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 8; s++) begin
                string t;
                case (m)
                    0: t = "R3 wrap4";
                    1: t = "R4 xor4";
                    2: t = "R5 wrap8";
                    default: t = "R6 xor8";
                endcase
                run_burst(int'($urandom_range(0, 127)) * 8 + s, m[1], m[0], t);
            end
        end

        // R9: start pulses during a running burst are ignored
        @(negedge clk);
        cur_tag = "R9 ignore";
        col_i = 10'h2A5; bl8_i = 1; ilv_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        col_i = 10'h013; bl8_i = 0; ilv_i = 1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (8) @(negedge clk);
        check("R9 no extra burst", int'(valid_o), 0);

        // R10: select changes mid-burst have no effect
        @(negedge clk);
        cur_tag = "R10 hold";
        col_i = 10'h3F6; bl8_i = 1; ilv_i = 1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        bl8_i = 0; ilv_i = 0; col_i = 10'h001;
        repeat (9) @(negedge clk);

        // R11: start held high, bursts run back to back
        cur_tag = "R11 chain";
        start_i = 1;
        for (int k = 0; k < 40; k++) begin
            col_i = COL_W'($urandom);
            bl8_i = k[2];
            ilv_i = k[0];
            @(negedge clk);
        end
        start_i = 0;
        repeat (10) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule